// File: doc/BRIEF.md
# Dual-Channel Host DMA Handshake Mailbox

This block lets an embedded CPU ask the DMA controller of an external host to move single bytes. Each of its two channels has a request line with an output enable, which gives the line a high-impedance state, and an active-low acknowledge input from the host. The channels work on their own: either can be in use, or both at once.

Software controls the block through one control register on a simple I/O bus. The register holds a request bit and an enable bit for each channel. Each of these fields has a write qualifier bit, so software can change one field without first reading the register. Software raises a request by setting the request bit. The hardware clears the bit once the host has acknowledged, and software polls the bit to learn that the transfer is done.

Each channel also holds one byte in a latch. A per-channel direction input selects the mode. In host-read mode the latch drives the host data lines while the acknowledge is low. In host-write mode the latch captures the host's byte when a transfer completes.

Top module: `dma_mailbox`

## Requirements
- R1: While `rst_n` is low at a clock edge, every request bit, enable bit and data latch is cleared. After that edge `host_req` and `host_req_oe` are 0, and a read of the control register returns 0x00.
- R2: `host_req_oe[c]` equals the enable bit of channel c. `host_req[c]` is 1 only when both the request bit and the enable bit of channel c are 1.
- R3: The control register is at address 0xD2. It reads as enable bits in bits 0 and 1, request bits in bits 4 and 5, and 0 in bits 2, 3, 6 and 7. The latch of channel c reads at address 0xD0+c. `cpu_rdata` is 0 when `cpu_rd` is low or the address maps to nothing.
- R4: A write to 0xD2 loads enable bit c from data bit c only if data bit 2+c is 1. It loads request bit c from data bit 4+c only if data bit 6+c is 1. A field whose qualifier is 0 keeps its value, so software can both set and clear a request bit.
- R5: A transfer on channel c completes when `host_ack_n[c]` rises while request bit c is set. The input passes through a two-flop synchronizer and an edge detector, so the request bit reads 0 after the third clock edge that samples `host_ack_n[c]` high.
- R6: If a software write to a request bit falls in the same cycle as that bit's hardware completion, the completion wins and the bit ends at 0.
- R7: The two channels are independent. Requests, enables, acknowledges and latches of one channel never change the other.
- R8: A write to address 0xD0+c loads the latch of channel c, and `host_dout` slice c always shows that latch. `host_dout_oe[c]` is 1 exactly when `xfer_to_host[c]` is 1 and `host_ack_n[c]` is 0.
- R9: When a completion happens on channel c while `xfer_to_host[c]` is 0, the latch loads `host_din` slice c sampled at the completion edge. This capture takes priority over a CPU latch write in the same cycle.
- R10: A rising acknowledge while the request bit is 0 is not a completion. The request bit and the latch keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 8 | CPU I/O address |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| host_req | output | 2 | Per-channel DMA request value, active high |
| host_req_oe | output | 2 | Per-channel request line output enable (0 = high impedance) |
| host_ack_n | input | 2 | Per-channel DMA acknowledge from host, active low, asynchronous |
| xfer_to_host | input | 2 | Per-channel direction: 1 = latch to host, 0 = host to latch |
| host_din | input | 16 | Host byte per channel, channel c in bits 8c+7..8c |
| host_dout | output | 16 | Latch contents per channel, channel c in bits 8c+7..8c |
| host_dout_oe | output | 2 | Per-channel data drive enable |

## Verification
The bench first uses directed writes with each qualifier bit on its own, which separates a field that updates from a neighbour that must stay put. Single-channel acknowledge pulses with the request bit set and with it clear show the difference between a real completion and an ignored edge. Overlapping pulses on both channels with different lengths separate independent channels from shared logic. A write placed on the exact completion cycle exposes the wrong priority. A long run of random bus and acknowledge traffic, checked against a behavioural model on every cycle, covers combinations the directed cases miss, such as latch writes that coincide with captures.

// File: rtl/mbx_pkg.sv
// Shared constants and types for the host DMA handshake mailbox.
// Assumes exactly two channels: the control register layout fixes that.
package mbx_pkg;
    parameter int unsigned MBX_NCH = 2;
    parameter int unsigned MBX_DW  = 8;
    parameter int unsigned MBX_AW  = 8;

    // Control register field positions (channel index is added to each)
    localparam int unsigned EN_LSB       = 0;
    localparam int unsigned EN_QUAL_LSB  = 2;
    localparam int unsigned REQ_LSB      = 4;
    localparam int unsigned REQ_QUAL_LSB = 6;

    // Per-channel decoded write controls
    typedef struct packed {
        logic en_we;
        logic en_val;
        logic req_we;
        logic req_val;
        logic dat_we;
    } chan_wr_t;
endpackage

// File: rtl/mbx_ack_sync.sv
// Synchronizes one asynchronous active-low acknowledge and flags its rising
// edge (end of acknowledge) as a one-cycle pulse.
// Assumes: ack_n idles high; STAGES >= 2. Flops reset to the idle level.
module mbx_ack_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    output logic done
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain;

    // Shift the acknowledge through the synchronizer and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[CHAIN-2:0], ack_n};
    end

    assign done = chain[STAGES-1] & ~chain[STAGES];

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
endmodule

// File: rtl/mbx_chan.sv
// One mailbox channel: enable bit, request bit, one-byte data latch and
// the request and data drive controls.
// Assumes: done is a one-cycle pulse already synchronized to clk.
module mbx_chan
    import mbx_pkg::*;
#(
    parameter int unsigned DW = MBX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_wr_t      wr,
    input  logic [DW-1:0] wdata,
    input  logic          done,
    input  logic          to_host,
    input  logic          ack_n,
    input  logic [DW-1:0] din,
    output logic          req_bit,
    output logic          en_bit,
    output logic [DW-1:0] latch,
    output logic          req_o,
    output logic          req_oe,
    output logic          dout_oe
);
    logic complete;
    assign complete = done & req_bit;

    // Enable bit: software only, qualified write
    always_ff @(posedge clk) begin
        if (!rst_n)        en_bit <= 1'b0;
        else if (wr.en_we) en_bit <= wr.en_val;
    end

    // Request bit: hardware completion beats a software write
    always_ff @(posedge clk) begin
        if (!rst_n)         req_bit <= 1'b0;
        else if (complete)  req_bit <= 1'b0;
        else if (wr.req_we) req_bit <= wr.req_val;
    end

    // Data latch: host capture beats a CPU load
    always_ff @(posedge clk) begin
        if (!rst_n)                    latch <= '0;
        else if (complete && !to_host) latch <= din;
        else if (wr.dat_we)            latch <= wdata;
    end

    assign req_o   = req_bit & en_bit;
    assign req_oe  = en_bit;
    assign dout_oe = to_host & ~ack_n;

    AST_RESET_CLR: assert property (@(posedge clk)
        !rst_n |=> (!req_bit && !en_bit)); // R1
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr.en_we |=> $stable(en_bit)); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr.req_we && !done) |=> $stable(req_bit)); // R4
    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_bit) |=> !req_bit); // R6
endmodule

// File: rtl/dma_mailbox.sv
// Dual-channel host DMA handshake mailbox: CPU I/O decode, read mux and
// two channel instances, each with its own acknowledge synchronizer.
// Assumes: cpu_wr is one cycle per write; read data is combinational.
module dma_mailbox
    import mbx_pkg::*;
#(
    parameter logic [MBX_AW-1:0] CTRL_ADDR   = 8'hD2,
    parameter logic [MBX_AW-1:0] DATA_BASE   = 8'hD0,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [MBX_AW-1:0]         cpu_addr,
    input  logic                      cpu_wr,
    input  logic                      cpu_rd,
    input  logic [MBX_DW-1:0]         cpu_wdata,
    output logic [MBX_DW-1:0]         cpu_rdata,
    output logic [MBX_NCH-1:0]        host_req,
    output logic [MBX_NCH-1:0]        host_req_oe,
    input  logic [MBX_NCH-1:0]        host_ack_n,
    input  logic [MBX_NCH-1:0]        xfer_to_host,
    input  logic [MBX_NCH*MBX_DW-1:0] host_din,
    output logic [MBX_NCH*MBX_DW-1:0] host_dout,
    output logic [MBX_NCH-1:0]        host_dout_oe
);
    localparam int unsigned NCH = MBX_NCH;
    localparam int unsigned DW  = MBX_DW;
    localparam int unsigned AW  = MBX_AW;

    logic          ctrl_wr;
    logic [NCH-1:0] req_bits, en_bits;
    logic [DW-1:0] latches [NCH];

    assign ctrl_wr = cpu_wr && (cpu_addr == CTRL_ADDR);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [AW-1:0] MY_DATA = AW'(int'(DATA_BASE) + c);
        chan_wr_t wr;
        logic     done;

        // Decode this channel's fields from the CPU write
        always_comb begin
            wr.en_we   = ctrl_wr && cpu_wdata[EN_QUAL_LSB + c];
            wr.en_val  = cpu_wdata[EN_LSB + c];
            wr.req_we  = ctrl_wr && cpu_wdata[REQ_QUAL_LSB + c];
            wr.req_val = cpu_wdata[REQ_LSB + c];
            wr.dat_we  = cpu_wr && (cpu_addr == MY_DATA);
        end

        mbx_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .ack_n (host_ack_n[c]),
            .done  (done)
        );

        mbx_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr),
            .wdata   (cpu_wdata),
            .done    (done),
            .to_host (xfer_to_host[c]),
            .ack_n   (host_ack_n[c]),
            .din     (host_din[c*DW +: DW]),
            .req_bit (req_bits[c]),
            .en_bit  (en_bits[c]),
            .latch   (latches[c]),
            .req_o   (host_req[c]),
            .req_oe  (host_req_oe[c]),
            .dout_oe (host_dout_oe[c])
        );

        assign host_dout[c*DW +: DW] = latches[c];
    end

    // Read mux: control register or a channel latch, else zero
    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            if (cpu_addr == CTRL_ADDR) begin
                for (int c = 0; c < NCH; c++) begin
                    cpu_rdata[EN_LSB + c]  = en_bits[c];
                    cpu_rdata[REQ_LSB + c] = req_bits[c];
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (cpu_addr == AW'(int'(DATA_BASE) + c)) cpu_rdata = latches[c];
            end
        end
    end
endmodule

// File: tb/dma_mailbox_test.sv
`timescale 1ns/1ps
module dma_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_addr = 8'h00;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic [1:0]  host_req, host_req_oe, host_dout_oe;
    logic [1:0]  host_ack_n = 2'b11;
    logic [1:0]  xfer_to_host = 2'b00;
    logic [15:0] host_din = 16'h0000;
    logic [15:0] host_dout;

    int    n_cmp = 0;
    int    n_mis = 0;
    string phase = "R1";
    bit    started = 0;

    always #2.5 clk = ~clk;

    dma_mailbox uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .host_req(host_req), .host_req_oe(host_req_oe), .host_ack_n(host_ack_n),
        .xfer_to_host(xfer_to_host), .host_din(host_din), .host_dout(host_dout),
        .host_dout_oe(host_dout_oe)
    );

    // Behavioural reference model
    bit       mreq [2];
    bit       men  [2];
    bit [7:0] mlat [2];
    bit       hist [2][$];

    initial begin
        for (int c = 0; c < 2; c++) hist[c] = '{1'b1, 1'b1, 1'b1};
    end

    always @(posedge clk) begin
        started = 1;
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                mreq[c] = 0; men[c] = 0; mlat[c] = 8'h00;
                hist[c] = '{1'b1, 1'b1, 1'b1};
            end else begin
                bit fin, ctl;
                fin = hist[c][1] && !hist[c][2] && mreq[c];
                ctl = cpu_wr && cpu_addr == 8'hD2;
                if (ctl && cpu_wdata[2+c]) men[c] = cpu_wdata[c];
                if (fin) mreq[c] = 0;
                else if (ctl && cpu_wdata[6+c]) mreq[c] = cpu_wdata[4+c];
                if (fin && !xfer_to_host[c]) mlat[c] = host_din[c*8 +: 8];
                else if (cpu_wr && cpu_addr == 8'hD0 + c) mlat[c] = cpu_wdata;
                hist[c].push_front(host_ack_n[c]);
                void'(hist[c].pop_back());
            end
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    // Compare every output to the model each cycle, away from the edge
    always @(negedge clk) begin
        #1;
        if (started) begin
            logic [7:0] erd;
            erd = 8'h00;
            if (cpu_rd) begin
                if (cpu_addr == 8'hD2) erd = {2'b00, mreq[1], mreq[0], 2'b00, men[1], men[0]};
                else if (cpu_addr == 8'hD0) erd = mlat[0];
                else if (cpu_addr == 8'hD1) erd = mlat[1];
            end
            chk("cpu_rdata", cpu_rdata, erd);
            for (int c = 0; c < 2; c++) begin
                chk($sformatf("host_req[%0d]", c), host_req[c], mreq[c] & men[c]);
                chk($sformatf("host_req_oe[%0d]", c), host_req_oe[c], men[c]);
                chk($sformatf("host_dout_oe[%0d]", c), host_dout_oe[c],
                    xfer_to_host[c] & ~host_ack_n[c]);
                chk($sformatf("host_dout[%0d]", c), host_dout[c*8 +: 8], mlat[c]);
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b1; cpu_addr = 8'hD2;
    endtask

    task automatic rd(logic [7:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
    endtask

    task automatic ack_pulse(int c, int lo);
        @(negedge clk); host_ack_n[c] = 1'b0;
        idle(lo);
        host_ack_n[c] = 1'b1;
    endtask

    initial begin
        phase = "R1";
        cpu_rd = 1'b1; cpu_addr = 8'hD2;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        phase = "R4"; wr(8'hD2, 8'h0F); idle(1);
        wr(8'hD2, 8'h04); idle(1);
        wr(8'hD2, 8'h33); idle(1);
        phase = "R2"; wr(8'hD2, 8'h50); idle(2);
        wr(8'hD2, 8'h05); idle(2);
        phase = "R5"; ack_pulse(0, 3); idle(6);
        phase = "R4"; wr(8'hD2, 8'h50); wr(8'hD2, 8'h40); idle(2);
        phase = "R7"; wr(8'hD2, 8'h0F); wr(8'hD2, 8'hF0);
        fork
            ack_pulse(0, 2);
            ack_pulse(1, 6);
        join
        idle(6);
        phase = "R8"; wr(8'hD0, 8'hA5); xfer_to_host = 2'b01;
        wr(8'hD2, 8'h50); ack_pulse(0, 3); rd(8'hD0); idle(6);
        phase = "R9"; xfer_to_host = 2'b00; host_din = 16'h3C00;
        wr(8'hD2, 8'h80 | 8'h20); ack_pulse(1, 2); host_din = 16'h0000;
        rd(8'hD1); idle(6);
        phase = "R10"; host_din = 16'h7777; ack_pulse(0, 2); ack_pulse(1, 2);
        idle(5); rd(8'hD0); rd(8'hD1); rd(8'hD2); idle(2);
        phase = "R6"; wr(8'hD2, 8'h50);
        @(negedge clk); host_ack_n[0] = 1'b0; idle(2);
        host_ack_n[0] = 1'b1; idle(2);
        cpu_addr = 8'hD2; cpu_wdata = 8'h50; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0; cpu_rd = 1'b1; idle(3);
        phase = "R3"; rd(8'hD5); rd(8'h52); @(negedge clk); cpu_rd = 1'b0; idle(2);
        phase = "R2/R3/R9 random";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            case ($urandom_range(0, 3))
                0: cpu_addr = 8'hD0;
                1: cpu_addr = 8'hD1;
                2: cpu_addr = 8'hD2;
                default: cpu_addr = 8'($urandom);
            endcase
            cpu_wr = ($urandom_range(0, 3) == 0);
            cpu_rd = $urandom_range(0, 1);
            cpu_wdata = 8'($urandom);
            if ($urandom_range(0, 3) == 0) host_ack_n = 2'($urandom);
            if ($urandom_range(0, 15) == 0) xfer_to_host = 2'($urandom);
            host_din = 16'($urandom);
        end
        phase = "R1"; @(negedge clk); cpu_wr = 1'b0; rst_n = 1'b0;
        cpu_rd = 1'b1; cpu_addr = 8'hD2; host_ack_n = 2'b11; idle(3);
        rst_n = 1'b1; idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        #1000000;
        n_cmp++; n_mis++;
        $display("FAIL watchdog %s actual=hung expected=done", phase);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule